// File: doc/BRIEF.md
# Active-Low Decimal Key to BCD Priority Encoder

This block turns a bank of decimal key lines into a four-bit BCD digit code. Each key line from 1 to 9 is active low: a line held at 0 means that digit is selected. The digit code leaves the block active low as well, so the four outputs carry the bitwise complement of the digit's binary value. There is no input line for digit zero. When no line is active, the encoded value is zero, and its complement makes all four outputs high.

When several lines are low at once, the highest-numbered active line decides the code. Lower lines are ignored. Because of this rule, a key matrix can feed the block without any arbitration in front of it.

A keyboard wrapper around the encoder adds a zero-key input. That line never reaches the code outputs. It only feeds a key-pressed flag, which other logic can use to see that any of the ten keys is down, including zero. The whole block is combinational: it has no clock, no reset and no state. Debouncing and scanning are done elsewhere.

Top module: `keypad_bcd_encoder`

## Requirements
- R1: With every digit line high (bits of `digitKeyN` all 1), `bcdCodeN` is 4'b1111, the complement of digit zero.
- R2: With only the line for digit d low (d from 1 to 9, carried on bit d-1 of `digitKeyN`), `bcdCodeN` equals the bitwise complement of the 4-bit binary value of d.
- R3: With several digit lines low, `bcdCodeN` is the complement of the highest digit among them. The states of lower lines have no effect.
- R4: With only digit 3 selected, `bcdCodeN` reads 4'b1100, the complement of true code 0011.
- R5: `zeroKeyN` has no effect on `bcdCodeN` for any pattern on `digitKeyN`.
- R6: `keyPressed` is 1 whenever `zeroKeyN` is 0 or any bit of `digitKeyN` is 0, including the case where the zero key is the only key down.
- R7: `keyPressed` is 0 when `zeroKeyN` and every bit of `digitKeyN` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digitKeyN | input | 9 | Active-low key lines for digits 1 to 9; bit i is digit i+1 |
| zeroKeyN | input | 1 | Active-low zero key; feeds only the pressed flag |
| bcdCodeN | output | 4 | Active-low BCD code of the winning digit |
| keyPressed | output | 1 | High when any of the ten keys is down |

## Verification
The bench sweeps all 512 digit-line patterns, each with the zero key both up and down, and computes the expected winner by searching from digit 9 downward.

- **Priority direction.** A design that resolved ties toward the lowest digit, or that ORed the codes of all active lines, gives wrong codes as soon as two lines are low. Pairs such as 3 with 4 and 7 with 8 expose this.
- **Output polarity and idle case.** A design that forgot the output inversion fails at the idle pattern and at the digit 3 pattern.
- **Zero key.** A design that let the zero key reach the code, or left it out of the pressed flag, fails when the zero key is the only key down.
- **Line-to-digit mapping.** An off-by-one mapping between line and digit shows up in the nine single-key patterns.

// File: rtl/keypad_enc_pkg.sv
package keypad_enc_pkg;
  localparam int KEY_DIGITS = 9;
  localparam int CODE_W     = $clog2(KEY_DIGITS + 1);

  typedef struct packed {
    logic                  anyActive;
    logic [KEY_DIGITS-1:0] grant;
  } enc_strobe_t;
endpackage

// File: rtl/digit_priority_ctrl.sv
module digit_priority_ctrl
  import keypad_enc_pkg::*;
(
  input  logic [KEY_DIGITS-1:0] keyReq,
  output enc_strobe_t           strobes
);
  logic [KEY_DIGITS-1:0] grantVec;

  generate
    for (genvar i = 0; i < KEY_DIGITS; i++) begin : g_grant
      if (i == KEY_DIGITS - 1) begin : g_top
        assign grantVec[i] = keyReq[i];
      end else begin : g_low
        assign grantVec[i] = keyReq[i] & ~(|keyReq[KEY_DIGITS-1:i+1]);
      end
    end
  endgenerate

  assign strobes.grant     = grantVec;
  assign strobes.anyActive = |keyReq;

  always_comb begin
    // R3
    grant_onehot_chk: assert ($onehot0(strobes.grant));
    // R1
    grant_idle_chk: assert ((keyReq != '0) || (strobes.grant == '0));
  end
endmodule

// File: rtl/bcd_code_datapath.sv
module bcd_code_datapath
  import keypad_enc_pkg::*;
(
  input  enc_strobe_t       strobes,
  output logic [CODE_W-1:0] codeN
);
  logic [CODE_W-1:0] codeTrue;

  always_comb begin
    codeTrue = '0;
    for (int i = 0; i < KEY_DIGITS; i++) begin
      if (strobes.grant[i]) codeTrue = codeTrue | CODE_W'(i + 1);
    end
  end

  assign codeN = ~codeTrue;

  always_comb begin
    // R1
    idle_code_chk: assert (strobes.anyActive || (codeN == '1));
    // R2
    active_code_chk: assert (!strobes.anyActive || (codeN != '1));
  end
endmodule

// File: rtl/decimal_bcd_core.sv
module decimal_bcd_core
  import keypad_enc_pkg::*;
(
  input  logic [KEY_DIGITS-1:0] lineN,
  output logic [CODE_W-1:0]     codeN
);
  enc_strobe_t strobes;

  digit_priority_ctrl u_ctrl (
    .keyReq  (~lineN),
    .strobes (strobes)
  );

  bcd_code_datapath u_dp (
    .strobes (strobes),
    .codeN   (codeN)
  );
endmodule

// File: rtl/keypad_bcd_encoder.sv
module keypad_bcd_encoder
  import keypad_enc_pkg::*;
(
  input  logic [8:0] digitKeyN,
  input  logic       zeroKeyN,
  output logic [3:0] bcdCodeN,
  output logic       keyPressed
);
  decimal_bcd_core u_core (
    .lineN (digitKeyN),
    .codeN (bcdCodeN)
  );

  assign keyPressed = ~(&{digitKeyN, zeroKeyN});

  always_comb begin
    // R6
    zero_flag_chk: assert (zeroKeyN || keyPressed);
    // R7
    idle_flag_chk: assert (!keyPressed || (bcdCodeN != 4'hF) || !zeroKeyN);
  end
endmodule

// File: tb/keypad_bcd_encoder_test.sv
module keypad_bcd_encoder_test;
  logic       clk = 1'b0;
  logic [8:0] digitKeyN;
  logic       zeroKeyN;
  logic [3:0] bcdCodeN;
  logic       keyPressed;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;

  always #5 clk = ~clk;

  keypad_bcd_encoder uut (
    .digitKeyN  (digitKeyN),
    .zeroKeyN   (zeroKeyN),
    .bcdCodeN   (bcdCodeN),
    .keyPressed (keyPressed)
  );

  task automatic checkCode(input string req, input logic [3:0] exp);
    checks++;
    if (bcdCodeN !== exp) begin
      fails++;
      $display("FAIL %s keys=%b zero=%b code=%b expected=%b", req, digitKeyN, zeroKeyN, bcdCodeN, exp);
    end
  endtask

  task automatic checkFlag(input string req, input logic exp);
    checks++;
    if (keyPressed !== exp) begin
      fails++;
      $display("FAIL %s keys=%b zero=%b pressed=%b expected=%b", req, digitKeyN, zeroKeyN, keyPressed, exp);
    end
  endtask

  task automatic apply(input logic [8:0] k, input logic z);
    @(posedge clk);
    digitKeyN = k;
    zeroKeyN  = z;
    @(negedge clk);
  endtask

  function automatic logic [3:0] expCode(input logic [8:0] k);
    for (int d = 9; d >= 1; d--) begin
      if (!k[d-1]) return ~4'(d);
    end
    return 4'hF;
  endfunction

  initial begin
    digitKeyN = '1;
    zeroKeyN  = 1'b1;
    apply(9'h1FF, 1'b1);
    checkCode("R1", 4'hF);
    checkFlag("R7", 1'b0);

    apply(~9'(1 << 2), 1'b1);
    checkCode("R4", 4'b1100);

    for (int d = 1; d <= 9; d++) begin
      apply(~9'(1 << (d - 1)), 1'b1);
      checkCode("R2", ~4'(d));
    end

    apply(~9'b000001100, 1'b1);
    checkCode("R3", ~4'd4);
    apply(~9'b011000000, 1'b1);
    checkCode("R3", ~4'd8);

    apply(9'h1FF, 1'b0);
    checkCode("R5", 4'hF);
    checkFlag("R6", 1'b1);

    for (int p = 0; p < 512; p++) begin
      for (int z = 0; z < 2; z++) begin
        apply(9'(p), 1'(z));
        if (($countones(9'(p)) > 1) && (z == 1)) checkCode("R3", expCode(9'(p)));
        else if (z == 0) checkCode("R5", expCode(9'(p)));
        else checkCode("R2", expCode(9'(p)));
        checkFlag(((p == 511) && (z == 1)) ? "R7" : "R6", !((p == 511) && (z == 1)));
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule